// File: doc/BRIEF.md
# Programmable Flag Controller

This block manages sixteen general-purpose flag pins from a plain register bus with a write strobe, an address and write data. Software chooses, pin by pin, whether the flag drives the pad or senses it. A driven flag takes its level from a stored output bit. A sensed flag goes through a two-stage synchronizer and is then conditioned by a per-pin polarity bit and a per-pin choice between level and edge sensitivity. In edge mode the pin keeps a sticky captured bit.

Two write-only command addresses change state without a read-modify-write. Ones written to the "raise" address set bits, and ones written to the "lower" address clear bits. On output pins they act on the driven level. On edge-mode input pins they act on the captured bit. A read of either command address returns the same mixed flag view: the driven level for outputs and the conditioned sense for inputs.

Top module: `pflag_ctrl`

## Requirements
- R1: After synchronous reset, the direction, polarity, edge-select and output-level registers are all zero. pin_oe and pin_out read 0, and a read of any address returns 0 while all pins are low.
- R2: Address 0 holds the direction register, and bit n = 1 makes pin n an output. pin_oe equals this register from the cycle after the write, and a read of address 0 returns it.
- R3: A write to address 1 sets the output level of every output pin whose data bit is 1, from the cycle after the write. Bits written as 0 leave their pins unchanged.
- R4: A write to address 2 clears the output level of every output pin whose data bit is 1. Bits written as 0 leave their pins unchanged.
- R5: Writes to addresses 1 and 2 do not change the stored level of a pin that is an input at the time of the write. This is seen on pin_out once the pin is made an output.
- R6: A read of address 1 and a read of address 2 return the same 16-bit flag view. For output pins this view shows the driven level.
- R7: Address 3 holds the polarity register, where bit 1 means active low. A level-mode input shows its synchronized pin value XOR its polarity bit in the flag view, two clock edges after the pin changes.
- R8: Address 4 holds the edge-select register, where bit 1 means edge mode. An edge-mode input captures a 1 on its active edge: rising when active high, falling when active low. The captured 1 holds after the pin returns to its idle level, and the flag view shows the captured bit.
- R9: On an edge-mode input, a 1 written to address 2 clears the captured bit and a 1 written to address 1 sets it.
- R10: If an active edge and a clear of the same pin's captured bit fall in the same cycle, the captured bit ends at 1.
- R11: While a pin is an output or in level mode, its captured bit is held at 0, so no stale capture appears after the pin returns to edge-mode input.
- R12: Addresses 5 to 7 read as 0, and writes to them change no register and no pin output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pad input levels, asynchronous |
| pin_out | output | 16 | Driven levels, 0 on input pins |
| pin_oe | output | 16 | Output enable per pin |

## Verification
The assertions check on every cycle the following behaviours: the output enable follows a direction write, set and clear commands reach exactly their output pins, pin levels hold when nothing is written, both command addresses show the driven level for outputs, and unmapped addresses read zero. The behaviour of the input side can only be shown by the bench scenarios. This covers synchronizer latency, polarity inversion, edge capture and its sticky hold, the same-cycle race between an edge and a clear, and the discarding of captures when the mode changes. These scenarios drive pin sequences and compare the flag view against a bench model.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    localparam int PF_PINS = 16;
    localparam int PF_AW   = 3;

    typedef enum logic [PF_AW-1:0] {
        PF_A_DIR   = 3'd0,
        PF_A_RAISE = 3'd1,
        PF_A_LOWER = 3'd2,
        PF_A_POL   = 3'd3,
        PF_A_EDGE  = 3'd4
    } pf_addr_e;

    typedef struct packed {
        logic dir_we;
        logic pol_we;
        logic edge_we;
        logic raise_we;
        logic lower_we;
    } pf_dec_t;

    function automatic pf_dec_t pf_decode(input logic wr, input logic [PF_AW-1:0] addr);
        pf_dec_t d;
        d = '0;
        if (wr) begin
            case (addr)
                PF_A_DIR:   d.dir_we   = 1'b1;
                PF_A_RAISE: d.raise_we = 1'b1;
                PF_A_LOWER: d.lower_we = 1'b1;
                PF_A_POL:   d.pol_we   = 1'b1;
                PF_A_EDGE:  d.edge_we  = 1'b1;
                default:    d = '0;
            endcase
        end
        return d;
    endfunction

    function automatic logic pf_active_edge(input logic cur, input logic prev, input logic pol);
        return (cur ^ pol) & ~(prev ^ pol);
    endfunction

endpackage

// File: rtl/pflag_sync.sv
module pflag_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pflag_regs.sv
module pflag_regs
    import pflag_pkg::*;
#(
    parameter int NPINS = PF_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [PF_AW-1:0] addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dir_o,
    output logic [NPINS-1:0] pol_o,
    output logic [NPINS-1:0] edge_o,
    output logic [NPINS-1:0] lvl_o,
    output logic [NPINS-1:0] raise_o,
    output logic [NPINS-1:0] lower_o
);
    pf_dec_t dec;
    logic [NPINS-1:0] dir_q, pol_q, edge_q, lvl_q;

    assign dec = pf_decode(wr, addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '0;
            pol_q  <= '0;
            edge_q <= '0;
            lvl_q  <= '0;
        end else begin
            if (dec.dir_we)   dir_q  <= wdata;
            if (dec.pol_we)   pol_q  <= wdata;
            if (dec.edge_we)  edge_q <= wdata;
            if (dec.raise_we) lvl_q  <= lvl_q | (wdata & dir_q);
            if (dec.lower_we) lvl_q  <= lvl_q & ~(wdata & dir_q);
        end
    end

    assign dir_o   = dir_q;
    assign pol_o   = pol_q;
    assign edge_o  = edge_q;
    assign lvl_o   = lvl_q;
    assign raise_o = dec.raise_we ? wdata : '0;
    assign lower_o = dec.lower_we ? wdata : '0;
endmodule

// File: rtl/pflag_cond.sv
module pflag_cond
    import pflag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sync_i,
    input  logic dir_i,
    input  logic pol_i,
    input  logic edge_mode_i,
    input  logic raise_i,
    input  logic lower_i,
    output logic sense_o
);
    logic prev_q;
    logic cap_q;
    logic cap_en;
    logic hit;

    assign cap_en = ~dir_i & edge_mode_i;
    assign hit    = pf_active_edge(sync_i, prev_q, pol_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            cap_q  <= 1'b0;
        end else begin
            prev_q <= sync_i;
            if (cap_en) begin
                cap_q <= hit | raise_i | (cap_q & ~lower_i);
            end else begin
                cap_q <= 1'b0;
            end
        end
    end

    assign sense_o = edge_mode_i ? cap_q : (sync_i ^ pol_i);
endmodule

// File: rtl/pflag_ctrl.sv
module pflag_ctrl
    import pflag_pkg::*;
#(
    parameter int NPINS = PF_PINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [PF_AW-1:0] bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe
);
    logic [NPINS-1:0] dir_r, pol_r, edge_r, lvl_r, raise_v, lower_v;
    logic [NPINS-1:0] sync_v, sense_v, flag_v;

    pflag_regs #(.NPINS(NPINS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .dir_o   (dir_r),
        .pol_o   (pol_r),
        .edge_o  (edge_r),
        .lvl_o   (lvl_r),
        .raise_o (raise_v),
        .lower_o (lower_v)
    );

    pflag_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (pin_in),
        .sync_o  (sync_v)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pflag_cond u_cond (
            .clk         (clk),
            .rst         (rst),
            .sync_i      (sync_v[i]),
            .dir_i       (dir_r[i]),
            .pol_i       (pol_r[i]),
            .edge_mode_i (edge_r[i]),
            .raise_i     (raise_v[i]),
            .lower_i     (lower_v[i]),
            .sense_o     (sense_v[i])
        );
        assign flag_v[i] = dir_r[i] ? lvl_r[i] : sense_v[i];
    end

    always_comb begin
        case (bus_addr)
            PF_A_DIR:   bus_rdata = dir_r;
            PF_A_RAISE: bus_rdata = flag_v;
            PF_A_LOWER: bus_rdata = flag_v;
            PF_A_POL:   bus_rdata = pol_r;
            PF_A_EDGE:  bus_rdata = edge_r;
            default:    bus_rdata = '0;
        endcase
    end

    assign pin_oe  = dir_r;
    assign pin_out = lvl_r & dir_r;
endmodule

// File: rtl/pflag_ctrl_chk.sv
module pflag_ctrl_chk
    import pflag_pkg::*;
#(
    parameter int NPINS = PF_PINS
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [PF_AW-1:0] bus_addr,
    input logic [NPINS-1:0] bus_wdata,
    input logic [NPINS-1:0] bus_rdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe
);
    p_reset_idle_r1: assert property (@(posedge clk)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0));

    p_dir_to_oe_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == PF_A_DIR) |=> (pin_oe == $past(bus_wdata)));

    p_raise_hits_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == PF_A_RAISE) |=>
        ((pin_out & $past(pin_oe) & $past(bus_wdata)) == ($past(pin_oe) & $past(bus_wdata))));

    p_lower_hits_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == PF_A_LOWER) |=>
        ((pin_out & $past(bus_wdata)) == '0));

    p_hold_no_write_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pin_out));

    p_view_outputs_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == PF_A_RAISE || bus_addr == PF_A_LOWER) |->
        (((bus_rdata ^ pin_out) & pin_oe) == '0));

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > PF_A_EDGE) |-> (bus_rdata == '0));
endmodule

bind pflag_ctrl pflag_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_pflag_ctrl.sv
`timescale 1ns/1ps
module tb_pflag_ctrl;
    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] m_dir = '0, m_pol = '0, m_edge = '0, m_lvl = '0, m_cap = '0;

    always #10 clk = ~clk;

    pflag_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [N-1:0] exp_flag();
        return (m_dir & m_lvl) | (~m_dir & m_edge & m_cap) | (~m_dir & ~m_edge & (pin_in ^ m_pol));
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        logic [N-1:0] en;
        en = ~m_dir & m_edge;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        case (a)
            3'd0: m_dir = d;
            3'd1: begin m_lvl = m_lvl | (d & m_dir); m_cap = m_cap | (d & en); end
            3'd2: begin m_lvl = m_lvl & ~(d & m_dir); m_cap = m_cap & ~(d & en); end
            3'd3: m_pol = d;
            3'd4: m_edge = d;
            default: ;
        endcase
        m_cap = m_cap & ~m_dir & m_edge;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic set_pins(input logic [N-1:0] p);
        logic [N-1:0] en;
        en = ~m_dir & m_edge;
        @(negedge clk);
        m_cap = m_cap | (en & (p ^ m_pol) & ~(pin_in ^ m_pol));
        pin_in = p;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_flag(input string req);
        logic [N-1:0] v;
        rd(3'd1, v);
        check(req, v, exp_flag());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_out", pin_out, '0);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 read", v, '0);
        end

        // R2 direction
        wr(3'd0, 16'h00FF);
        check("R2 pin_oe", pin_oe, 16'h00FF);
        rd(3'd0, v); check("R2 readback", v, 16'h00FF);

        // R3 raise on outputs
        wr(3'd1, 16'h0011);
        check("R3 raise", pin_out, 16'h0011);
        // R5 raise on an input pin leaves its level untouched
        wr(3'd1, 16'h0100);
        check("R5 input raise", pin_out, 16'h0011);

        // R6 both command addresses show driven level
        rd(3'd1, v); check("R6 view addr1", v & 16'h00FF, 16'h0011);
        rd(3'd2, v); check("R6 view addr2", v & 16'h00FF, 16'h0011);

        // R4 lower
        wr(3'd2, 16'h0001);
        check("R4 lower", pin_out, 16'h0010);

        // R7 level sense and polarity
        set_pins(16'h0F00);
        rd(3'd1, v); check("R7 level high", v & 16'hFF00, 16'h0F00);
        wr(3'd3, 16'hFF00);
        rd(3'd1, v); check("R7 active low", v & 16'hFF00, 16'hF000);
        wr(3'd3, 16'h0000);

        // R5 observed after making pin 8 an output
        wr(3'd0, 16'h01FF);
        check("R5 pin8 level", pin_out, 16'h0010);
        wr(3'd0, 16'h00FF);

        // R8 edge capture and hold
        wr(3'd4, 16'hFF00);
        set_pins(16'h0000);
        rd(3'd1, v); check("R8 falling ignored", v & 16'hFF00, 16'h0000);
        set_pins(16'h3000);
        set_pins(16'h0000);
        rd(3'd1, v); check("R8 rising held", v & 16'hFF00, 16'h3000);
        // R9 lower and raise on captured bits
        wr(3'd2, 16'h1000);
        rd(3'd1, v); check("R9 lower cap", v & 16'hFF00, 16'h2000);
        wr(3'd1, 16'h4000);
        rd(3'd1, v); check("R9 raise cap", v & 16'hFF00, 16'h6000);
        // R8 active-low pin falls
        wr(3'd3, 16'h8000);
        set_pins(16'h8000);
        rd(3'd1, v); check("R8 rise on active low", v & 16'h8000, 16'h0000);
        set_pins(16'h0000);
        rd(3'd1, v); check("R8 fall on active low", v & 16'h8000, 16'h8000);
        wr(3'd3, 16'h0000);

        // R10 edge beats lower in the same cycle
        wr(3'd2, 16'hFF00);
        rd(3'd1, v); check("R10 pre-clear", v & 16'hFF00, 16'h0000);
        @(negedge clk);
        pin_in = 16'h0200;
        @(posedge clk);
        @(posedge clk);
        wr(3'd2, 16'h0200);
        m_cap = m_cap | 16'h0200;
        rd(3'd1, v); check("R10 race", v & 16'h0200, 16'h0200);

        // R11 capture dropped when pin leaves edge-mode input
        wr(3'd0, 16'h02FF);
        wr(3'd0, 16'h00FF);
        rd(3'd1, v); check("R11 after output", v & 16'h0200, 16'h0000);
        wr(3'd1, 16'h0400);
        wr(3'd4, 16'hFB00);
        wr(3'd4, 16'hFF00);
        rd(3'd1, v); check("R11 after level", v & 16'h0400, 16'h0000);

        // R12 unmapped addresses
        wr(3'd6, 16'hFFFF);
        rd(3'd6, v); check("R12 read 6", v, '0);
        rd(3'd7, v); check("R12 read 7", v, '0);
        rd(3'd0, v); check("R12 dir kept", v, 16'h00FF);
        rd(3'd3, v); check("R12 pol kept", v, 16'h0000);
        rd(3'd4, v); check("R12 edge kept", v, 16'hFF00);
        check("R12 pins kept", pin_out, 16'h0010);

        // constrained random mix against the model (R2-R9, R11)
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                set_pins(16'($urandom));
            end else begin
                int a;
                a = $urandom_range(0, 5);
                wr(3'(a), 16'($urandom));
            end
            check_flag("R8 random flag view");
            check("R2 random oe", pin_oe, m_dir);
            check("R3 random out", pin_out, m_dir & m_lvl);
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule